// File: doc/BRIEF.md
# Dual-Channel SAR Converter Serial Acquisition Controller

This block runs two serial successive-approximation converters that share one chip select and one serial clock. Each sample period has two phases. First comes an acquisition phase of a programmable number of system-clock cycles, with chip select released and the serial clock parked high. Then comes a transfer phase of fourteen serial-clock cycles, in which both converters shift out their results together. The serial clock is the 100 MHz system clock divided by two. The sample rate is therefore 100 MHz / (28 + n), which is 3.03 MSPS for n = 5.

Each channel's data line is sampled on every rising serial-clock edge. The first two bits of a frame are discarded. The remaining twelve bits, most significant first, form that channel's result. When the transfer ends, both results are released together as one 24-bit pair on a valid/ready output. The converters cannot be paused, so back-pressure never stalls acquisition. A pair that has not been accepted is held stable while ready is low, and it is replaced by the next pair if that pair completes first. The newest data always wins, and valid stays high across the replacement.

The acquisition length comes from a plain input. It is sampled only when a period starts, and a value of zero is treated as one.

Top module: `sar_pair_acq`

## Requirements
- R1: While reset is held, cs_n_o is 1, sck_o is 1 and pair_valid_o is 0.
- R2: sck_o is 1 in every cycle in which cs_n_o is 1, so the serial clock is parked high throughout acquisition.
- R3: Every transfer keeps cs_n_o at 0 for exactly 28 system cycles. sck_o is 0 in the first of those cycles and toggles every system cycle, giving exactly 14 rising serial-clock edges per transfer.
- R4: Each acquisition phase lasts n system cycles with cs_n_o at 1. n is the value of acq_cycles_i at the clock edge on which cs_n_o returns to 1 (or during reset), so a full period is 28 + n cycles.
- R5: An acq_cycles_i value of 0 gives an acquisition phase of 1 system cycle.
- R6: A change of acq_cycles_i during an acquisition phase does not alter that phase. It takes effect from the next period.
- R7: miso_i is sampled on the system edge on which sck_o rises. The first two sampled bits of a frame are discarded, whatever their value, and the next twelve form the result, most significant bit first.
- R8: Both channels are sampled on the same edges. pair_data_o[11:0] holds channel 0 (miso_i[0]) and pair_data_o[23:12] holds channel 1 (miso_i[1]).
- R9: pair_valid_o rises in the first cycle after each transfer, the cycle in which cs_n_o returns to 1. While pair_valid_o is 1 and pair_ready_i is 0, pair_data_o stays stable until the next transfer ends.
- R10: If a new pair completes while the previous one has not been accepted, the new pair replaces it and pair_valid_o stays 1.
- R11: After a cycle with pair_valid_o and pair_ready_i both 1, pair_valid_o is 0 in the next cycle, unless a transfer ends on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_cycles_i | input | 8 | Acquisition length n, in system cycles |
| sck_o | output | 1 | Shared serial clock (system clock / 2), held high during acquisition |
| cs_n_o | output | 1 | Shared active-low chip select, low only during transfer |
| miso_i | input | 2 | Serial data from converter 0 (bit 0) and converter 1 (bit 1) |
| pair_valid_o | output | 1 | A result pair is available |
| pair_ready_i | input | 1 | The consumer accepts the pair in this cycle |
| pair_data_o | output | 24 | {channel 1 result, channel 0 result} |

## Verification
The hardest situation to reach is a change of acq_cycles_i that lands partway through an acquisition phase. It must not shorten or lengthen the phase already running. The stimulus first lets one full period start with a long acquisition. It then changes the value a cycle after chip select has risen. The length of that phase and of the following one are measured at the pins.

The other two cases that are hard to reach are a pair that is overwritten while back-pressure holds it, and leading bits that are set to one. Both are produced by a converter model in the bench, which serves each frame on the falling serial-clock edges.

// File: rtl/sar_acq_pkg.sv
package sar_acq_pkg;

  typedef enum logic {
    PH_ACQ  = 1'b0,
    PH_XFER = 1'b1
  } acq_phase_e;

  // A requested acquisition length of zero is promoted to one cycle.
  function automatic int unsigned eff_len(input int unsigned req);
    return (req == 0) ? 1 : req;
  endfunction

endpackage

// File: rtl/sar_acq_timing.sv
module sar_acq_timing
  import sar_acq_pkg::*;
#(
  parameter int ACQW = 8,
  parameter int LEAD = 2,
  parameter int RES  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ACQW-1:0] acq_cycles_i,
  output logic            sck_o,
  output logic            cs_n_o,
  output logic            cap_en_o,
  output logic            done_o
);
  localparam int XFER  = LEAD + RES;
  localparam int EDGES = 2 * XFER;
  localparam int ECW   = $clog2(EDGES);
  localparam int BIW   = ECW - 1;
  localparam logic [ECW-1:0] EDGE_LAST = ECW'(EDGES - 1);

  acq_phase_e      ph_q;
  logic [ECW-1:0]  edge_q;
  logic [ACQW-1:0] acq_q;
  logic [ACQW-1:0] nlat_q;
  logic            sck_q;
  logic            csn_q;
  logic [BIW-1:0]  bit_idx;
  logic            acq_end;
  logic [ACQW-1:0] n_next;

  assign n_next   = ACQW'(eff_len(32'(acq_cycles_i)));
  assign bit_idx  = edge_q[ECW-1:1];
  assign acq_end  = (ph_q == PH_ACQ) && (acq_q == nlat_q - 1'b1);
  assign done_o   = (ph_q == PH_XFER) && (edge_q == EDGE_LAST);
  // Sample on the edge that drives the serial clock from low to high.
  assign cap_en_o = (ph_q == PH_XFER) && !edge_q[0] && (bit_idx >= BIW'(LEAD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_ACQ;
      edge_q <= '0;
      acq_q  <= '0;
      nlat_q <= n_next;
      sck_q  <= 1'b1;
      csn_q  <= 1'b1;
    end else begin
      case (ph_q)
        PH_ACQ: begin
          if (acq_end) begin
            ph_q   <= PH_XFER;
            edge_q <= '0;
            acq_q  <= '0;
            sck_q  <= 1'b0;
            csn_q  <= 1'b0;
          end else begin
            acq_q <= acq_q + 1'b1;
          end
        end
        default: begin
          if (edge_q == EDGE_LAST) begin
            ph_q   <= PH_ACQ;
            nlat_q <= n_next;
            sck_q  <= 1'b1;
            csn_q  <= 1'b1;
          end else begin
            edge_q <= edge_q + 1'b1;
            sck_q  <= !edge_q[0];
          end
        end
      endcase
    end
  end

  assign sck_o  = sck_q;
  assign cs_n_o = csn_q;

endmodule

// File: rtl/sar_acq_shift.sv
module sar_acq_shift #(
  parameter int RES = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en_i,
  input  logic           miso_i,
  output logic [RES-1:0] word_o
);
  logic [RES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        sh_q <= '0;
    else if (cap_en_i) sh_q <= {sh_q[RES-2:0], miso_i};
  end

  assign word_o = sh_q;

endmodule

// File: rtl/sar_acq_outreg.sv
module sar_acq_outreg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load_i) begin
      vld_q <= 1'b1;   // newer pair replaces an unaccepted one
      dat_q <= data_i;
    end else if (vld_q && ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign valid_o = vld_q;
  assign data_o  = dat_q;

endmodule

// File: rtl/sar_pair_acq.sv
module sar_pair_acq #(
  parameter int ACQW = 8,
  parameter int LEAD = 2,
  parameter int RES  = 12,
  parameter int NCH  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ACQW-1:0]    acq_cycles_i,
  output logic               sck_o,
  output logic               cs_n_o,
  input  logic [NCH-1:0]     miso_i,
  output logic               pair_valid_o,
  input  logic               pair_ready_i,
  output logic [NCH*RES-1:0] pair_data_o
);
  localparam int PW = NCH * RES;

  logic          cap_en;
  logic          done;
  logic [PW-1:0] bundle;

  sar_acq_timing #(.ACQW(ACQW), .LEAD(LEAD), .RES(RES)) u_tim (
    .clk          (clk),
    .rst_n        (rst_n),
    .acq_cycles_i (acq_cycles_i),
    .sck_o        (sck_o),
    .cs_n_o       (cs_n_o),
    .cap_en_o     (cap_en),
    .done_o       (done)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    sar_acq_shift #(.RES(RES)) u_sh (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en_i (cap_en),
      .miso_i   (miso_i[ch]),
      .word_o   (bundle[ch*RES +: RES])
    );
  end

  sar_acq_outreg #(.W(PW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (done),
    .data_i  (bundle),
    .ready_i (pair_ready_i),
    .valid_o (pair_valid_o),
    .data_o  (pair_data_o)
  );

endmodule

// File: rtl/sar_pair_acq_chk.sv
module sar_pair_acq_chk #(
  parameter int XFER_CYC = 28,
  parameter int W        = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sck_o,
  input logic         cs_n_o,
  input logic         pair_valid_o,
  input logic         pair_ready_i,
  input logic [W-1:0] pair_data_o
);
  localparam int LCW = $clog2(XFER_CYC + 2) + 1;
  logic [LCW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       lo_cnt <= '0;
    else if (!cs_n_o) lo_cnt <= lo_cnt + 1'b1;
    else              lo_cnt <= '0;
  end

  // R2
  acq_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sck_o);

  // R3
  xfer_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !sck_o);

  // R3
  xfer_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(!cs_n_o)) |-> (sck_o != $past(sck_o)));

  // R3
  xfer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (lo_cnt == LCW'(XFER_CYC)));

  // R9
  valid_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> pair_valid_o);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pair_valid_o && !pair_ready_i) && !$rose(cs_n_o)) |->
      (pair_valid_o && $stable(pair_data_o)));

  // R11
  drop_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pair_valid_o && pair_ready_i) && !$rose(cs_n_o)) |-> !pair_valid_o);

endmodule

bind sar_pair_acq sar_pair_acq_chk #(
  .XFER_CYC (2 * (LEAD + RES)),
  .W        (NCH * RES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sck_o        (sck_o),
  .cs_n_o       (cs_n_o),
  .pair_valid_o (pair_valid_o),
  .pair_ready_i (pair_ready_i),
  .pair_data_o  (pair_data_o)
);

// File: tb/sim_sar_pair_acq.sv
`timescale 1ns/1ps
module sim_sar_pair_acq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  acq_cycles_i = 8'd5;
  logic        sck_o, cs_n_o;
  logic [1:0]  miso = 2'b00;
  logic        pair_valid_o;
  logic        pair_ready_i = 1'b1;
  logic [23:0] pair_data_o;

  sar_pair_acq u0 (
    .clk(clk), .rst_n(rst_n), .acq_cycles_i(acq_cycles_i),
    .sck_o(sck_o), .cs_n_o(cs_n_o), .miso_i(miso),
    .pair_valid_o(pair_valid_o), .pair_ready_i(pair_ready_i),
    .pair_data_o(pair_data_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Converter model: a frame is {two leading bits, 12-bit word}, sent MSB first.
  // The first bit appears when the frame opens; each later bit follows a falling sck.
  logic [11:0] wrd [2];
  logic [1:0]  lead [2];
  logic [13:0] frm [2];
  int  idx = 0;
  bit  in_frame = 0;

  always @(negedge sck_o) begin
    if (!in_frame) begin
      in_frame = 1;
      idx = 0;
      for (int c = 0; c < 2; c++) frm[c] = {lead[c], wrd[c]};
    end else begin
      idx++;
    end
    if (idx <= 13)
      for (int c = 0; c < 2; c++) miso[c] = frm[c][13-idx];
  end

  always @(posedge cs_n_o) in_frame = 0;

  // Pin monitor, sampled on falling clock edges.
  int hi_run = 0, lo_run = 0, rises = 0;
  int last_hi = 0, last_lo = 0, last_rises = 0;
  bit low_sck_acq = 0;
  logic cs_p = 1'b1, sck_p = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n_o) begin
        if (!cs_p) begin
          last_lo = lo_run; last_rises = rises; lo_run = 0; rises = 0;
        end
        hi_run++;
        if (!sck_o) low_sck_acq = 1;
      end else begin
        if (cs_p) begin last_hi = hi_run; hi_run = 0; end
        lo_run++;
        if (sck_o && !sck_p) rises++;
      end
      cs_p = cs_n_o;
      sck_p = sck_o;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cs_rise();
    logic p;
    p = cs_n_o;
    forever begin
      @(negedge clk);
      if (!p && cs_n_o) break;
      p = cs_n_o;
    end
  endtask

  task automatic wait_cs_fall();
    logic p;
    p = cs_n_o;
    forever begin
      @(negedge clk);
      if (p && !cs_n_o) break;
      p = cs_n_o;
    end
  endtask

  logic [23:0] got;
  logic        got_valid;

  task automatic run_pair(input logic [7:0] n, input logic [11:0] w0, input logic [11:0] w1,
                          input logic [1:0] l0, input logic [1:0] l1);
    acq_cycles_i = n;
    wrd[0] = w0; wrd[1] = w1; lead[0] = l0; lead[1] = l1;
    wait_cs_rise();
    wait_cs_rise();
    got_valid = pair_valid_o;
    got = pair_data_o;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 cs_n in reset", int'(cs_n_o), 1);
    check("R1 sck in reset", int'(sck_o), 1);
    check("R1 valid in reset", int'(pair_valid_o), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    pair_ready_i = 1'b1;
    run_pair(8'd5, 12'hA5C, 12'h3F1, 2'b00, 2'b00);
    check("R9 valid after transfer", int'(got_valid), 1);
    check("R8 channel layout", int'(got), int'({12'h3F1, 12'hA5C}));
    check("R4 acquisition length n=5", last_hi, 5);
    @(negedge clk);
    check("R3 transfer length", last_lo, 28);
    check("R3 rising sck edges", last_rises, 14);
    check("R2 sck high in acquisition", int'(low_sck_acq), 0);
    check("R11 valid cleared after handshake", int'(pair_valid_o), 0);
  endtask

  task automatic t_lead();
    run_pair(8'd2, 12'h001, 12'h800, 2'b11, 2'b10);
    check("R7 leading bits dropped, MSB first", int'(got), int'({12'h800, 12'h001}));
    @(negedge clk);
  endtask

  task automatic t_nzero();
    run_pair(8'd0, 12'hFFF, 12'h000, 2'b00, 2'b00);
    check("R5 n=0 gives one cycle", last_hi, 1);
    check("R8 data with n=0", int'(got), int'({12'h000, 12'hFFF}));
    @(negedge clk);
  endtask

  task automatic t_nchange();
    run_pair(8'd20, 12'h123, 12'h456, 2'b00, 2'b00);
    check("R4 acquisition length n=20", last_hi, 20);
    acq_cycles_i = 8'd3;          // in the middle of a 20-cycle acquisition
    wait_cs_fall();
    @(negedge clk);
    check("R6 running phase unchanged", last_hi, 20);
    wait_cs_rise();
    wait_cs_fall();
    @(negedge clk);
    check("R6 new length next period", last_hi, 3);
  endtask

  task automatic t_backpressure();
    pair_ready_i = 1'b0;
    wrd[0] = 12'h0F0; wrd[1] = 12'hE01; lead[0] = 2'b00; lead[1] = 2'b00;
    wait_cs_rise();
    wait_cs_rise();
    check("R9 first pair held", int'(pair_data_o), int'({12'hE01, 12'h0F0}));
    wrd[0] = 12'h777; wrd[1] = 12'h2C3;
    wait_cs_rise();
    @(negedge clk);
    check("R10 valid kept on overwrite", int'(pair_valid_o), 1);
    check("R10 newer pair replaces", int'(pair_data_o), int'({12'h2C3, 12'h777}));
    pair_ready_i = 1'b1;
    @(negedge clk);
    check("R11 valid cleared after late accept", int'(pair_valid_o), 0);
  endtask

  initial begin
    wrd[0] = 12'h0; wrd[1] = 12'h0; lead[0] = 2'b00; lead[1] = 2'b00;
    t_reset();
    t_basic();
    t_lead();
    t_nzero();
    t_nchange();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule